// File: doc/BRIEF.md
# Accumulator-File ALU with Skip

This block is the execute stage of a small 8-bit accumulator machine. Each cycle it may accept one already-decoded operation together with a 7-bit register address, a destination-select bit and an 8-bit literal. It reads a private 128-byte register file and the accumulator W, forms the result, and on the next rising clock edge writes that result either to W or back into the addressed register.

A zero flag is kept for the operations that report on their result. The two skip-on-zero operations leave that flag alone and instead raise a one-cycle skip request, which the surrounding sequencer uses to squash the following instruction.

Top module: `accFileAlu`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears W, the zero flag, the skip request and every register file byte to 0x00.
- R2: opCode encodings are 0 decrement, 1 increment, 2 decrement-skip, 3 increment-skip, 4 OR-literal, 5 OR-register; codes 6 and 7, or opValid low, change nothing and leave skipReq low.
- R3: For all operations except OR-literal, destSel=0 writes the result to W and leaves the register unchanged; destSel=1 writes the addressed register and leaves W unchanged.
- R4: Decrement and increment compute f-1 and f+1 modulo 256 and update the zero flag.
- R5: Decrement-skip and increment-skip compute f-1 and f+1 modulo 256, write them per destSel, and leave the zero flag unchanged.
- R6: skipReq is high for exactly the cycle after a skip operation whose 8-bit result is 0x00, and low after every other cycle.
- R7: OR-literal writes W OR literal into W regardless of destSel, updates the zero flag and leaves the register file unchanged.
- R8: OR-register computes W OR f, writes it per destSel and updates the zero flag.
- R9: When the zero flag is updated it becomes 1 if the 8-bit result is 0x00 and 0 otherwise; all writes occur on the rising edge after the operation is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| opValid | input | 1 | Operation strobe |
| opCode | input | 3 | Decoded operation select |
| regAddr | input | 7 | Register file address |
| destSel | input | 1 | 0 = result to W, 1 = result to register |
| literal | input | 8 | Immediate operand for OR-literal |
| wReg | output | 8 | Accumulator W |
| zFlag | output | 1 | Zero flag |
| skipReq | output | 1 | Skip request for the next instruction |

## Verification
The register file has no read port, so its contents can only be seen by routing them into W: the bench reads a byte back with an increment whose destination is W, which leaves the byte intact and shows it plus one. The hardest state to reach is a skip with the zero flag already cleared, which needs a byte driven to 0xFF by a plain decrement and then a flag-clearing operation before the increment-skip wraps it to zero; the vector table builds that chain, and a later mid-run reset followed by a read-back shows the file was cleared.

// File: rtl/accAluPkg.sv
package accAluPkg;

  typedef enum logic [2:0] {
    OP_DEC     = 3'd0,
    OP_INC     = 3'd1,
    OP_DECSKIP = 3'd2,
    OP_INCSKIP = 3'd3,
    OP_ORLIT   = 3'd4,
    OP_ORREG   = 3'd5
  } aluOp_e;

  typedef struct packed {
    logic       wrW;
    logic       wrF;
    logic       updZ;
    logic       skipEn;
    logic [2:0] aluSel;
  } aluCtl_t;

endpackage

// File: rtl/accAluCtrl.sv
module accAluCtrl
  import accAluPkg::*;
(
  input  logic       opValid,
  input  logic [2:0] opCode,
  input  logic       destSel,
  output aluCtl_t    ctl
);

  always_comb begin
    ctl = '0;
    ctl.aluSel = opCode;
    if (opValid) begin
      case (opCode)
        OP_DEC, OP_INC: begin
          ctl.wrW  = !destSel;
          ctl.wrF  = destSel;
          ctl.updZ = 1'b1;
        end
        OP_DECSKIP, OP_INCSKIP: begin
          ctl.wrW    = !destSel;
          ctl.wrF    = destSel;
          ctl.skipEn = 1'b1;
        end
        OP_ORLIT: begin
          ctl.wrW  = 1'b1;
          ctl.updZ = 1'b1;
        end
        OP_ORREG: begin
          ctl.wrW  = !destSel;
          ctl.wrF  = destSel;
          ctl.updZ = 1'b1;
        end
        default: ctl = '0;
      endcase
    end
  end

endmodule

// File: rtl/accAluPath.sv
module accAluPath
  import accAluPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  aluCtl_t           ctl,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] literal,
  output logic [DATA_W-1:0] wReg,
  output logic              zFlag,
  output logic              skipReq
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] regFile [DEPTH];
  logic [DATA_W-1:0] fileRd;
  logic [DATA_W-1:0] result;
  logic              resZero;

  assign fileRd  = regFile[regAddr];
  assign resZero = (result == '0);

  always_comb begin
    case (ctl.aluSel)
      OP_DEC, OP_DECSKIP: result = fileRd - DATA_W'(1);
      OP_INC, OP_INCSKIP: result = fileRd + DATA_W'(1);
      OP_ORLIT:           result = wReg | literal;
      OP_ORREG:           result = wReg | fileRd;
      default:            result = fileRd;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wReg    <= '0;
      zFlag   <= 1'b0;
      skipReq <= 1'b0;
      for (int i = 0; i < DEPTH; i++) regFile[i] <= '0;
    end else begin
      skipReq <= ctl.skipEn && resZero;
      if (ctl.wrW)  wReg <= result;
      if (ctl.wrF)  regFile[regAddr] <= result;
      if (ctl.updZ) zFlag <= resZero;
    end
  end

endmodule

// File: rtl/accFileAlu.sv
module accFileAlu
  import accAluPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              opValid,
  input  logic [2:0]        opCode,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              destSel,
  input  logic [DATA_W-1:0] literal,
  output logic [DATA_W-1:0] wReg,
  output logic              zFlag,
  output logic              skipReq
);

  aluCtl_t ctl;

  accAluCtrl u_ctrl (
    .opValid (opValid),
    .opCode  (opCode),
    .destSel (destSel),
    .ctl     (ctl)
  );

  accAluPath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_path (
    .clk     (clk),
    .rst     (rst),
    .ctl     (ctl),
    .regAddr (regAddr),
    .literal (literal),
    .wReg    (wReg),
    .zFlag   (zFlag),
    .skipReq (skipReq)
  );

endmodule

// File: rtl/accFileAluChk.sv
module accFileAluChk
  import accAluPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              opValid,
  input logic [2:0]        opCode,
  input logic [ADDR_W-1:0] regAddr,
  input logic              destSel,
  input logic [DATA_W-1:0] literal,
  input logic [DATA_W-1:0] wReg,
  input logic              zFlag,
  input logic              skipReq
);

  logic isSkipOp;
  logic isKnownOp;
  assign isSkipOp  = (opCode == OP_DECSKIP) || (opCode == OP_INCSKIP);
  assign isKnownOp = (opCode <= 3'(OP_ORREG));

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (wReg == '0) && !zFlag && !skipReq);

  // R2
  idle_no_change_chk: assert property (@(posedge clk) disable iff (rst)
    (!opValid || !isKnownOp) |=> $stable(wReg) && $stable(zFlag) && !skipReq);

  // R3
  dest_reg_keeps_w_chk: assert property (@(posedge clk) disable iff (rst)
    (opValid && destSel && isKnownOp && opCode != OP_ORLIT) |=> $stable(wReg));

  // R5
  skip_keeps_z_chk: assert property (@(posedge clk) disable iff (rst)
    (opValid && isSkipOp) |=> $stable(zFlag));

  // R6
  skip_only_after_skipop_chk: assert property (@(posedge clk) disable iff (rst)
    !(opValid && isSkipOp) |=> !skipReq);

  // R7
  orlit_result_chk: assert property (@(posedge clk) disable iff (rst)
    (opValid && opCode == OP_ORLIT) |=> wReg == ($past(wReg) | $past(literal)));

  // R9
  orlit_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (opValid && opCode == OP_ORLIT) |=> zFlag == (wReg == '0));

endmodule

bind accFileAlu accFileAluChk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk (
  .clk     (clk),
  .rst     (rst),
  .opValid (opValid),
  .opCode  (opCode),
  .regAddr (regAddr),
  .destSel (destSel),
  .literal (literal),
  .wReg    (wReg),
  .zFlag   (zFlag),
  .skipReq (skipReq)
);

// File: tb/accFileAlu_test.sv
module accFileAlu_test;

  logic       clk = 1'b0;
  logic       rst;
  logic       opValid;
  logic [2:0] opCode;
  logic [6:0] regAddr;
  logic       destSel;
  logic [7:0] literal;
  logic [7:0] wReg;
  logic       zFlag;
  logic       skipReq;

  int nRun  = 0;
  int nFail = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  accFileAlu uut (
    .clk(clk), .rst(rst), .opValid(opValid), .opCode(opCode),
    .regAddr(regAddr), .destSel(destSel), .literal(literal),
    .wReg(wReg), .zFlag(zFlag), .skipReq(skipReq)
  );

  // {valid, op, addr, d, lit, expW, expZ, expSkip}
  localparam int NV = 20;
  localparam logic [29:0] VEC [NV] = '{
    {1'b1, 3'd1, 7'd5,   1'b1, 8'h00, 8'h00, 1'b0, 1'b0}, // R4 R3 inc f5 -> 1
    {1'b1, 3'd1, 7'd5,   1'b0, 8'h00, 8'h02, 1'b0, 1'b0}, // R3 inc f5 to W
    {1'b1, 3'd0, 7'd9,   1'b1, 8'h00, 8'h02, 1'b0, 1'b0}, // R4 dec wrap f9 -> FF
    {1'b1, 3'd1, 7'd9,   1'b1, 8'h00, 8'h02, 1'b1, 1'b0}, // R4 R9 inc wrap f9 -> 0, Z
    {1'b1, 3'd3, 7'd9,   1'b1, 8'h00, 8'h02, 1'b1, 1'b0}, // R5 incskip f9 -> 1, Z kept
    {1'b1, 3'd2, 7'd9,   1'b1, 8'h00, 8'h02, 1'b1, 1'b1}, // R6 decskip f9 -> 0, skip
    {1'b1, 3'd2, 7'd9,   1'b0, 8'h00, 8'hFF, 1'b1, 1'b0}, // R5 decskip to W
    {1'b1, 3'd4, 7'd9,   1'b1, 8'h00, 8'hFF, 1'b0, 1'b0}, // R7 orlit ignores d
    {1'b1, 3'd0, 7'd127, 1'b1, 8'h00, 8'hFF, 1'b0, 1'b0}, // R4 dec f127 -> FF
    {1'b1, 3'd3, 7'd127, 1'b1, 8'h00, 8'hFF, 1'b0, 1'b1}, // R5 R6 incskip wrap, Z stays 0
    {1'b1, 3'd7, 7'd5,   1'b1, 8'h00, 8'hFF, 1'b0, 1'b0}, // R2 code 7 no effect
    {1'b1, 3'd6, 7'd127, 1'b0, 8'h00, 8'hFF, 1'b0, 1'b0}, // R2 code 6 no effect
    {1'b1, 3'd0, 7'd5,   1'b0, 8'h00, 8'h00, 1'b1, 1'b0}, // R4 dec f5 to W = 0
    {1'b1, 3'd4, 7'd0,   1'b0, 8'h00, 8'h00, 1'b1, 1'b0}, // R7 R9 orlit zero
    {1'b1, 3'd5, 7'd5,   1'b0, 8'h00, 8'h01, 1'b0, 1'b0}, // R8 orreg to W
    {1'b1, 3'd4, 7'd0,   1'b0, 8'h80, 8'h81, 1'b0, 1'b0}, // R7 orlit 80
    {1'b1, 3'd5, 7'd9,   1'b1, 8'h00, 8'h81, 1'b0, 1'b0}, // R8 orreg to f9 = 81
    {1'b1, 3'd1, 7'd9,   1'b0, 8'h00, 8'h82, 1'b0, 1'b0}, // R8 read back f9 = 81
    {1'b0, 3'd1, 7'd5,   1'b1, 8'h00, 8'h82, 1'b0, 1'b0}, // R2 valid low
    {1'b1, 3'd1, 7'd5,   1'b0, 8'h00, 8'h02, 1'b0, 1'b0}  // R2 R7 f5 still 1
  };

  task automatic check(input string req, input logic [7:0] eW,
                       input logic eZ, input logic eS);
    nRun++;
    if (wReg !== eW || zFlag !== eZ || skipReq !== eS) begin
      nFail++;
      $display("FAIL %s: got W=%h Z=%b S=%b expected W=%h Z=%b S=%b",
               req, wReg, zFlag, skipReq, eW, eZ, eS);
    end
  endtask

  task automatic apply(input logic v, input logic [2:0] op, input logic [6:0] a,
                       input logic d, input logic [7:0] k);
    @(negedge clk);
    opValid = v; opCode = op; regAddr = a; destSel = d; literal = k;
    @(negedge clk);
    opValid = 1'b0;
  endtask

  initial begin
    rst = 1'b1; opValid = 1'b0; opCode = '0; regAddr = '0; destSel = 1'b0; literal = '0;
    repeat (3) @(negedge clk);
    check("R1 reset", 8'h00, 1'b0, 1'b0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][29], VEC[i][28:26], VEC[i][25:19], VEC[i][18], VEC[i][17:10]);
      check($sformatf("vector %0d", i), VEC[i][9:2], VEC[i][1], VEC[i][0]);
    end

    // R6: skip pulse lasts one cycle
    apply(1'b1, 3'd0, 7'd3, 1'b1, 8'h00);   // f3 -> FF
    apply(1'b1, 3'd3, 7'd3, 1'b1, 8'h00);   // f3 -> 00, skip
    check("R6 skip raised", 8'h02, 1'b0, 1'b1);
    apply(1'b0, 3'd0, 7'd0, 1'b0, 8'h00);
    check("R6 skip one cycle", 8'h02, 1'b0, 1'b0);

    // R1: mid-run reset clears file
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1 mid reset", 8'h00, 1'b0, 1'b0);
    apply(1'b1, 3'd1, 7'd9, 1'b0, 8'h00);   // f9 was 81
    check("R1 file cleared", 8'h01, 1'b0, 1'b0);
    apply(1'b1, 3'd1, 7'd3, 1'b0, 8'h00);
    check("R1 file cleared f3", 8'h01, 1'b0, 1'b0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        nRun++; nFail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule